// File: doc/BRIEF.md
# Host-Gated Multichannel Block Capture

This block sits between a multichannel acquisition front end and an outbound FIFO that feeds a host. The front end delivers one sample per channel on every scan, one sample per valid cycle, marking the first sample of each scan with a scan strobe and tagging every sample with its channel index. The block stays idle and drops everything until the host sends a one-cycle request. From then on it waits for the start of a fresh scan and passes exactly one block of consecutive scans into the FIFO. Within each scan the samples are interleaved by channel, so the host can split them by position alone.

When the FIFO reports full, the offered sample is lost instead of replacing older data. It still counts toward the block, so the block keeps its fixed length and its alignment. A sticky flag records the loss and is reported with the completion pulse. The default build has 16 channels, 120 scans per block (1920 samples) and 24-bit samples. The FIFO behind the block is expected to hold two blocks.

Top module: `scan_block_capture`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, fifo_wr_en, busy, blk_done and blk_ovf are all 0.
- R2: While no block has been requested (busy low), no valid sample is written, whatever the values of smp_first and smp_chan.
- R3: A host_req pulse seen while busy is low raises busy in the next cycle.
- R4: After a request, the first write is the first later sample that has smp_valid=1, smp_first=1 and smp_chan=0. Samples before it are discarded, including mid-scan samples, a channel-0 sample without the strobe, and a strobed sample in the same cycle as the request.
- R5: During a block, each valid sample goes out in the same cycle with fifo_wr_data equal to smp_data, in arrival order. Idle input cycles are skipped. Exactly NUM_CH*NUM_SCANS samples are taken per block, and a block with no loss makes exactly that many writes.
- R6: A sample offered while fifo_full=1 is not written, but it still counts toward the block length.
- R7: blk_done is high for exactly one cycle, the cycle after the final sample of the block is taken. busy is low in that cycle.
- R8: blk_ovf is high only together with blk_done. It is 1 if and only if at least one sample of that block met fifo_full=1, and it starts clear for every new block.
- R9: A host_req pulse while busy is high is ignored: after the block completes, no further samples are written until a new request arrives.
- R10: The in-block position (scan index times NUM_CH plus channel index) restarts from zero for each block, so back-to-back requested blocks each take the full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | One-cycle block request from the host |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_first | input | 1 | Scan strobe: this sample starts a scan |
| smp_chan | input | CH_W | Channel index of the sample |
| smp_data | input | SAMPLE_W | Signed fixed-point sample |
| fifo_full | input | 1 | Outbound FIFO cannot take a write this cycle |
| fifo_wr_en | output | 1 | Write strobe to the FIFO |
| fifo_wr_data | output | SAMPLE_W | Data written to the FIFO |
| busy | output | 1 | A block is armed or in progress |
| blk_done | output | 1 | One-cycle completion pulse |
| blk_ovf | output | 1 | With blk_done: the block lost at least one sample |

## Verification
The write strobe and data depend on the inputs of the same cycle. The bench therefore drives each sample at the falling edge and checks fifo_wr_en and fifo_wr_data two nanoseconds later, before the next rising edge. busy rises one cycle after the request. blk_done and blk_ovf appear one cycle after the final sample is taken, so the bench checks them at the falling edge that follows that sample's rising edge, and checks that blk_done has dropped again one cycle later. The bench uses a 4-channel, 3-scan build. Within it, the drop positions (including the final sample), the gap patterns and the request timing are swept, and every expected word is computed from the block, scan and channel numbers.

// File: rtl/bcap_pkg.sv
// Package: shared types for the block capture.
// Assumes: nothing beyond IEEE 1800-2017.
package bcap_pkg;

    // Control states of the capture sequencer
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2
    } bcap_state_e;

endpackage

// File: rtl/bcap_pos_counter.sv
// Module: bcap_pos_counter
// Tracks the channel and scan position inside a block and flags the final
// sample. The flat position is scan*NUM_CH + chan.
// Assumes: samples arrive in channel order; NUM_CH >= 2, NUM_SCANS >= 2.
module bcap_pos_counter #(
    parameter int NUM_CH    = 16,
    parameter int NUM_SCANS = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last_o
);
    localparam int BLOCK_LEN = NUM_CH * NUM_SCANS;
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int SCAN_W    = (NUM_SCANS > 1) ? $clog2(NUM_SCANS) : 1;
    localparam int IDX_W     = $clog2(BLOCK_LEN + 1);
    localparam logic [CH_W-1:0]  CH_LAST = CH_W'(NUM_CH - 1);
    localparam logic [IDX_W-1:0] NCH_L   = IDX_W'(NUM_CH);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(BLOCK_LEN - 1);

    logic [CH_W-1:0]   chan_q;
    logic [SCAN_W-1:0] scan_q;
    logic [IDX_W-1:0]  idx;

    // Flat sample position from scan and channel
    always_comb begin
        idx = IDX_W'(scan_q) * NCH_L + IDX_W'(chan_q);
    end

    assign last_o = (idx == IDX_END);

    // Advance channel, then scan, on each taken sample
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            chan_q <= '0;
            scan_q <= '0;
        end else if (step) begin
            if (chan_q == CH_LAST) begin
                chan_q <= '0;
                scan_q <= scan_q + 1'b1;
            end else begin
                chan_q <= chan_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bcap_ctrl.sv
// Module: bcap_ctrl
// Sequencer: idle until requested, armed until a scan start on channel 0,
// then capturing until the final sample. Produces the done pulse.
// Assumes: host_req is a single-cycle pulse; last is valid with accept.
module bcap_ctrl
    import bcap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        smp_valid,
    input  logic        start_hit,
    input  logic        last,
    output bcap_state_e state_o,
    output logic        accept_o,
    output logic        block_start_o,
    output logic        busy_o,
    output logic        done_o
);
    bcap_state_e state_q;

    // A sample is taken in capture, or as the aligned first sample when armed
    always_comb begin
        block_start_o = (state_q == ST_ARMED) && start_hit;
        accept_o      = block_start_o || ((state_q == ST_CAPTURE) && smp_valid);
    end

    // State transitions; requests outside idle are ignored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:    if (host_req) state_q <= ST_ARMED;
                ST_ARMED:   if (accept_o) state_q <= last ? ST_IDLE : ST_CAPTURE;
                ST_CAPTURE: if (accept_o && last) state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // One-cycle completion pulse after the final sample
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= accept_o && last;
    end

    assign state_o = state_q;
    assign busy_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/bcap_ovf_track.sv
// Module: bcap_ovf_track
// Sticky record of samples lost to a full FIFO within the current block,
// reported alongside the done pulse.
// Assumes: block_start coincides with the first accepted sample.
module bcap_ovf_track (
    input  logic clk,
    input  logic rst_n,
    input  logic block_start,
    input  logic accept,
    input  logic fifo_full,
    input  logic last,
    output logic ovf_o
);
    logic sticky_q;

    // Restart on the first sample, then accumulate losses
    always_ff @(posedge clk) begin
        if (!rst_n)           sticky_q <= 1'b0;
        else if (block_start) sticky_q <= fifo_full;
        else if (accept && fifo_full) sticky_q <= 1'b1;
    end

    // Report the loss state together with completion
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_o <= 1'b0;
        else        ovf_o <= accept && last && ((sticky_q && !block_start) || fifo_full);
    end
endmodule

// File: rtl/scan_block_capture.sv
// Module: scan_block_capture (top)
// Host-gated capture of one aligned, interleaved block of scans into an
// outbound FIFO. Writes pass through combinationally; lost samples still
// count toward the block length.
// Assumes: fifo_full reflects whether a write in this cycle would be taken;
// the front end delivers channels 0..NUM_CH-1 in order within a scan.
module scan_block_capture
    import bcap_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int NUM_SCANS = 120,
    parameter int SAMPLE_W  = 24,
    parameter int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_req,
    input  logic                smp_valid,
    input  logic                smp_first,
    input  logic [CH_W-1:0]     smp_chan,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                fifo_full,
    output logic                fifo_wr_en,
    output logic [SAMPLE_W-1:0] fifo_wr_data,
    output logic                busy,
    output logic                blk_done,
    output logic                blk_ovf
);
    localparam int BLOCK_LEN = NUM_CH * NUM_SCANS;

    bcap_state_e state;
    logic        start_hit;
    logic        accept;
    logic        block_start;
    logic        last;
    logic        pos_clear;

    // Aligned start: strobed sample on channel 0
    assign start_hit = smp_valid && smp_first && (smp_chan == '0);
    assign pos_clear = (state == ST_IDLE);

    bcap_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_req      (host_req),
        .smp_valid     (smp_valid),
        .start_hit     (start_hit),
        .last          (last),
        .state_o       (state),
        .accept_o      (accept),
        .block_start_o (block_start),
        .busy_o        (busy),
        .done_o        (blk_done)
    );

    bcap_pos_counter #(
        .NUM_CH    (NUM_CH),
        .NUM_SCANS (NUM_SCANS)
    ) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (pos_clear),
        .step   (accept),
        .last_o (last)
    );

    bcap_ovf_track u_ovf (
        .clk         (clk),
        .rst_n       (rst_n),
        .block_start (block_start),
        .accept      (accept),
        .fifo_full   (fifo_full),
        .last        (last),
        .ovf_o       (blk_ovf)
    );

    // Drop rather than overwrite when the FIFO is full
    assign fifo_wr_en   = accept && !fifo_full;
    assign fifo_wr_data = smp_data;
endmodule

// File: rtl/bcap_chk.sv
// Module: bcap_chk
// Property checker for scan_block_capture, attached by bind below.
// Assumes: observed through the top-level ports only.
module bcap_chk #(
    parameter int BLOCK_LEN = 1920
) (
    input logic clk,
    input logic rst_n,
    input logic host_req,
    input logic fifo_full,
    input logic fifo_wr_en,
    input logic busy,
    input logic blk_done,
    input logic blk_ovf
);
    logic [31:0] wr_cnt;

    // Count writes of the current block; clear once idle
    always_ff @(posedge clk) begin
        if (!rst_n)          wr_cnt <= '0;
        else if (fifo_wr_en) wr_cnt <= wr_cnt + 1;
        else if (!busy)      wr_cnt <= '0;
    end

    a_r2_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fifo_wr_en);
    a_r3_busy_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_req) |=> busy);
    a_r6_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_wr_en);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);
    a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> !busy);
    a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> blk_done);
    a_r8_ovf_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        blk_ovf |-> blk_done);
    a_r5_write_budget: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> (wr_cnt <= BLOCK_LEN));
    a_r5_full_block: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && !blk_ovf) |-> (wr_cnt == BLOCK_LEN));
endmodule

bind scan_block_capture bcap_chk #(.BLOCK_LEN(BLOCK_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .fifo_full  (fifo_full),
    .fifo_wr_en (fifo_wr_en),
    .busy       (busy),
    .blk_done   (blk_done),
    .blk_ovf    (blk_ovf)
);

// File: tb/scan_block_capture_tb_top.sv
// Bench for scan_block_capture on a 4-channel, 3-scan build.
module scan_block_capture_tb_top;
    localparam int NCH  = 4;
    localparam int NSC  = 3;
    localparam int BLEN = NCH * NSC;
    localparam int SW   = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          smp_valid = 1'b0;
    logic          smp_first = 1'b0;
    logic [1:0]    smp_chan = '0;
    logic [SW-1:0] smp_data = '0;
    logic          fifo_full = 1'b0;
    logic          fifo_wr_en;
    logic [SW-1:0] fifo_wr_data;
    logic          busy;
    logic          blk_done;
    logic          blk_ovf;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    scan_block_capture #(.NUM_CH(NCH), .NUM_SCANS(NSC), .SAMPLE_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .smp_valid(smp_valid),
        .smp_first(smp_first), .smp_chan(smp_chan), .smp_data(smp_data),
        .fifo_full(fifo_full), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
        .busy(busy), .blk_done(blk_done), .blk_ovf(blk_ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Drive one cycle at the falling edge; leave checks 2 ns later
    task automatic tick(input bit v, input bit f, input int ch, input int d,
                        input bit full, input bit req);
        @(negedge clk);
        smp_valid = v; smp_first = f; smp_chan = 2'(ch);
        smp_data = SW'(d); fifo_full = full; host_req = req;
        #2;
    endtask

    function automatic int word(input int blk, input int idx);
        return blk * 24'h10000 + (idx / NCH) * 24'h100 + (idx % NCH);
    endfunction

    // One aligned block; drops at da/db; optional gaps; request pulse at rq
    task automatic run_block(input int blk, input int da, input int db,
                             input bit gaps, input int rq);
        int writes = 0;
        bit lost = 0;
        for (int i = 0; i < BLEN; i++) begin
            bit full = (i == da) || (i == db);
            if (gaps && (i % 3 == 2)) begin
                tick(0, 0, 0, 0, 0, 0);
                chk(fifo_wr_en == 0, "R5 gap", fifo_wr_en, 0);
            end
            tick(1, (i % NCH) == 0, i % NCH, word(blk, i), full, i == rq);
            lost |= full;
            chk(fifo_wr_en == !full, full ? "R6 drop" : "R5 write", fifo_wr_en, !full);
            if (!full) begin
                writes++;
                chk(fifo_wr_data == SW'(word(blk, i)), "R5 data", fifo_wr_data, word(blk, i));
            end
            if (i < BLEN - 1) chk(blk_done == 0, "R7 early", blk_done, 0);
        end
        tick(0, 0, 0, 0, 0, 0);
        chk(blk_done == 1, "R7 done", blk_done, 1);
        chk(busy == 0, "R7 busy", busy, 0);
        chk(blk_ovf == lost, "R8 ovf", blk_ovf, lost);
        chk(writes == BLEN - int'(da >= 0) - int'(db >= 0 && db != da), "R10 count", writes, BLEN);
        tick(0, 0, 0, 0, 0, 0);
        chk(blk_done == 0, "R7 single", blk_done, 0);
        chk(blk_ovf == 0, "R8 only_with_done", blk_ovf, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<20000", cycles);
                summary();
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (3) tick(1, 1, 0, 5, 0, 1);
        chk(busy == 0 && fifo_wr_en == 0, "R1 in reset", {busy, fifo_wr_en}, 0);
        chk(blk_done == 0 && blk_ovf == 0, "R1 in reset", {blk_done, blk_ovf}, 0);
        @(negedge clk); rst_n = 1'b1; host_req = 0; smp_valid = 0;
        #2;
        chk(busy == 0 && blk_done == 0, "R1 after release", {busy, blk_done}, 0);

        // R2: no request, full scans offered
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < NCH; c++) begin
                tick(1, c == 0, c, 77, 0, 0);
                chk(fifo_wr_en == 0, "R2 idle", fifo_wr_en, 0);
            end

        // R3 and R4: request, then misaligned samples are discarded
        tick(0, 0, 0, 0, 0, 1);
        tick(0, 0, 0, 0, 0, 0);
        chk(busy == 1, "R3 busy", busy, 1);
        tick(1, 0, 2, 9, 0, 0);
        chk(fifo_wr_en == 0, "R4 midscan", fifo_wr_en, 0);
        tick(1, 0, 0, 9, 0, 0);
        chk(fifo_wr_en == 0, "R4 nostrobe", fifo_wr_en, 0);
        tick(1, 1, 1, 9, 0, 0);
        chk(fifo_wr_en == 0, "R4 strobe_ch1", fifo_wr_en, 0);

        // R5, R9: clean block with a request mid-block
        run_block(1, -1, -1, 0, 5);
        for (int c = 0; c < NCH; c++) begin
            tick(1, c == 0, c, 3, 0, 0);
            chk(fifo_wr_en == 0, "R9 ignored", fifo_wr_en, 0);
        end

        // R4: request together with a strobed ch0 sample is not taken
        tick(1, 1, 0, 4, 0, 1);
        chk(fifo_wr_en == 0, "R4 same_cycle", fifo_wr_en, 0);
        // R6, R8: sweep a drop over every position
        for (int p = 0; p < BLEN; p++) begin
            if (p > 0) tick(0, 0, 0, 0, 0, 1);
            run_block(2 + p, p, BLEN - 1 - p, p % 2, -1);
        end

        // R8, R10: clean block after lossy ones, with gaps
        tick(0, 0, 0, 0, 0, 1);
        run_block(40, -1, -1, 1, -1);
        tick(0, 0, 0, 0, 0, 1);
        run_block(41, -1, -1, 0, -1);
        summary();
    end
endmodule